// File: doc/BRIEF.md
# Bidirectional Byte Transceiver with Parity Generation and Checking

This block passes one byte in either direction between two tristate-capable ports, A and B. A direction input selects the route. When it is high, port A is read and its value is driven onto port B. When it is low, port B is read and its value is driven onto port A. Each pad is split into a data-in vector, a data-out vector and an output-enable vector, so the block can sit behind the chip's pad ring. It contains no storage and every output follows the inputs combinationally.

Alongside the data path sits a parity unit. It uses one shared pin whose role depends on the direction. While transmitting, that pin is driven with parity computed over the A byte, and an odd/even select sets the sense. While receiving, the same pin is read as an incoming parity bit. The B byte, the select and the incoming bit together decide a status flag. That flag is high when the parity is consistent and low when it is not.

A single active-high shutdown input releases every pad at once: both data ports, the parity pin and the status pin.

Top module: `xfer_parity_transceiver`

## Requirements
- R1: With `shutdown` low and `dir_a2b` high, `b_oe` is all ones, `b_out` equals `a_in` bit for bit (no inversion), and `a_oe` is all zeros.
- R2: With `shutdown` low and `dir_a2b` low, `a_oe` is all ones, `a_out` equals `b_in` bit for bit (no inversion), and `b_oe` is all zeros.
- R3: With `shutdown` high, `a_oe`, `b_oe`, `par_oe` and `ok_oe` are all zero, whatever the other inputs are.
- R4: With `shutdown` low and `dir_a2b` high, `par_oe` is 1 and `par_out` equals the XOR of all `a_in` bits XOR `odd_sel`. For example, an even number of ones with `odd_sel` = 1 gives `par_out` = 1.
- R5: With `dir_a2b` high, `ok_oe` is 0 and `par_in` has no effect on any output.
- R6: With `shutdown` low and `dir_a2b` low, `ok_oe` is 1, `par_oe` is 0, and `ok_out` equals NOT(XOR of all `b_in` bits XOR `odd_sel` XOR `par_in`). Here 1 means the parity matches and 0 means a mismatch. For example, an odd count of ones with `odd_sel` = 1 and `par_in` = 1 gives 0.
- R7: Any output whose enable bit is 0 carries 0 on that bit (`a_out`, `b_out`, `par_out`, `ok_out`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shutdown | input | 1 | Active high; releases every pad |
| dir_a2b | input | 1 | 1: A drives B and parity is generated; 0: B drives A and parity is checked |
| odd_sel | input | 1 | Parity sense select |
| a_in | input | WIDTH | Value read from the A pads |
| a_out | output | WIDTH | Value driven onto the A pads |
| a_oe | output | WIDTH | Per-bit drive enable for the A pads |
| b_in | input | WIDTH | Value read from the B pads |
| b_out | output | WIDTH | Value driven onto the B pads |
| b_oe | output | WIDTH | Per-bit drive enable for the B pads |
| par_in | input | 1 | Value read from the shared parity pad |
| par_out | output | 1 | Value driven onto the parity pad when transmitting |
| par_oe | output | 1 | Drive enable for the parity pad |
| ok_out | output | 1 | Parity status, high when the parity matches |
| ok_oe | output | 1 | Drive enable for the status pad |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between any input and any output. The bench therefore changes the inputs on the rising clock edge and samples every output on the following falling edge. This leaves half a period for the logic to settle, and no sample shares an edge with a stimulus change. An exhaustive sweep and a seeded random phase both follow this pattern, with each vector held for exactly one cycle.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

   typedef enum logic {
      ROUTE_B2A = 1'b0,
      ROUTE_A2B = 1'b1
   } route_e;

   typedef enum logic {
      PTREE_CHAIN    = 1'b0,
      PTREE_BALANCED = 1'b1
   } ptree_e;

endpackage

// File: rtl/xfer_parity_tree.sv
module xfer_parity_tree #(
   parameter int              WIDTH = 8,
   parameter xfer_pkg::ptree_e STYLE = xfer_pkg::PTREE_BALANCED
) (
   input  logic [WIDTH-1:0] data,
   output logic             odd
);

   localparam int LEVELS = $clog2(WIDTH);
   localparam int PADDED = 1 << LEVELS;

   if (WIDTH < 2) begin : g_bad_width
      $error("xfer_parity_tree: WIDTH must be at least 2");
   end

   if (STYLE == xfer_pkg::PTREE_CHAIN) begin : g_chain
      logic [WIDTH:0] acc;
      assign acc[0] = 1'b0;
      for (genvar i = 0; i < WIDTH; i++) begin : g_link
         assign acc[i+1] = acc[i] ^ data[i];
      end
      assign odd = acc[WIDTH];
   end else begin : g_balanced
      // node[1] is the root; leaves occupy PADDED..2*PADDED-1
      logic [2*PADDED-1:0] node;
      for (genvar l = 0; l < PADDED; l++) begin : g_leaf
         if (l < WIDTH) begin : g_real
            assign node[PADDED+l] = data[l];
         end else begin : g_pad
            assign node[PADDED+l] = 1'b0;
         end
      end
      for (genvar n = 1; n < PADDED; n++) begin : g_node
         assign node[n] = node[2*n] ^ node[2*n+1];
      end
      assign node[0] = 1'b0;
      assign odd = node[1];
   end

endmodule

// File: rtl/xfer_lane_steer.sv
module xfer_lane_steer #(
   parameter int WIDTH = 8
) (
   input  logic             active,
   input  logic             a2b,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] a_out,
   output logic [WIDTH-1:0] a_oe,
   output logic [WIDTH-1:0] b_out,
   output logic [WIDTH-1:0] b_oe
);

   logic drive_a;
   logic drive_b;

   assign drive_b = active &  a2b;
   assign drive_a = active & ~a2b;

   for (genvar i = 0; i < WIDTH; i++) begin : g_lane
      assign b_oe[i]  = drive_b;
      assign a_oe[i]  = drive_a;
      assign b_out[i] = drive_b & a_in[i];
      assign a_out[i] = drive_a & b_in[i];
   end

endmodule

// File: rtl/xfer_parity_ctrl.sv
module xfer_parity_ctrl #(
   parameter int               WIDTH = 8,
   parameter xfer_pkg::ptree_e STYLE = xfer_pkg::PTREE_BALANCED
) (
   input  logic             active,
   input  logic             a2b,
   input  logic             odd_sel,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             par_in,
   output logic             par_out,
   output logic             par_oe,
   output logic             ok_out,
   output logic             ok_oe
);

   logic odd_a;
   logic odd_b;
   logic gen_bit;
   logic mismatch;

   xfer_parity_tree #(.WIDTH(WIDTH), .STYLE(STYLE)) u_tree_a (
      .data (a_in),
      .odd  (odd_a)
   );

   xfer_parity_tree #(.WIDTH(WIDTH), .STYLE(STYLE)) u_tree_b (
      .data (b_in),
      .odd  (odd_b)
   );

   always_comb begin
      gen_bit  = odd_a ^ odd_sel;
      mismatch = odd_b ^ odd_sel ^ par_in;
      par_oe   = active & a2b;
      ok_oe    = active & ~a2b;
      par_out  = par_oe & gen_bit;
      ok_out   = ok_oe & ~mismatch;
   end

endmodule

// File: rtl/xfer_parity_transceiver.sv
module xfer_parity_transceiver #(
   parameter int               WIDTH = 8,
   parameter xfer_pkg::ptree_e STYLE = xfer_pkg::PTREE_BALANCED
) (
   input  logic             shutdown,
   input  logic             dir_a2b,
   input  logic             odd_sel,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic [WIDTH-1:0] a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic [WIDTH-1:0] b_oe,
   input  logic             par_in,
   output logic             par_out,
   output logic             par_oe,
   output logic             ok_out,
   output logic             ok_oe
);

   logic active;
   logic a2b;

   assign active = ~shutdown;
   assign a2b    = (xfer_pkg::route_e'(dir_a2b) == xfer_pkg::ROUTE_A2B);

   xfer_lane_steer #(.WIDTH(WIDTH)) u_steer (
      .active (active),
      .a2b    (a2b),
      .a_in   (a_in),
      .b_in   (b_in),
      .a_out  (a_out),
      .a_oe   (a_oe),
      .b_out  (b_out),
      .b_oe   (b_oe)
   );

   xfer_parity_ctrl #(.WIDTH(WIDTH), .STYLE(STYLE)) u_par (
      .active  (active),
      .a2b     (a2b),
      .odd_sel (odd_sel),
      .a_in    (a_in),
      .b_in    (b_in),
      .par_in  (par_in),
      .par_out (par_out),
      .par_oe  (par_oe),
      .ok_out  (ok_out),
      .ok_oe   (ok_oe)
   );

endmodule

// File: rtl/xfer_parity_transceiver_chk.sv
module xfer_parity_transceiver_chk #(
   parameter int WIDTH = 8
) (
   input logic             shutdown,
   input logic             dir_a2b,
   input logic             odd_sel,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] a_out,
   input logic [WIDTH-1:0] a_oe,
   input logic [WIDTH-1:0] b_in,
   input logic [WIDTH-1:0] b_out,
   input logic [WIDTH-1:0] b_oe,
   input logic             par_in,
   input logic             par_out,
   input logic             par_oe,
   input logic             ok_out,
   input logic             ok_oe
);

   always_comb begin
      AST_B_SIDE_ROUTE: assert (shutdown || !dir_a2b || (b_oe == '1 && a_oe == '0 && b_out == a_in)); // R1
      AST_A_SIDE_ROUTE: assert (shutdown || dir_a2b || (a_oe == '1 && b_oe == '0 && a_out == b_in)); // R2
      AST_ALL_RELEASED: assert (!shutdown || (a_oe == '0 && b_oe == '0 && !par_oe && !ok_oe)); // R3
      AST_GEN_PARITY: assert (shutdown || !dir_a2b || (par_oe && par_out == (^a_in ^ odd_sel))); // R4
      AST_NO_STATUS_TX: assert (!dir_a2b || !ok_oe); // R5
      AST_CHECK_PARITY: assert (shutdown || dir_a2b || (ok_oe && !par_oe && ok_out == !(^b_in ^ odd_sel ^ par_in))); // R6
      AST_QUIET_WHEN_OFF: assert (((a_out & ~a_oe) == '0) && ((b_out & ~b_oe) == '0) && (par_oe || !par_out) && (ok_oe || !ok_out)); // R7
   end

endmodule

bind xfer_parity_transceiver xfer_parity_transceiver_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/xfer_parity_transceiver_test.sv
module xfer_parity_transceiver_test;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         shutdown, dir_a2b, odd_sel, par_in;
   logic [W-1:0] a_in, b_in;
   logic [W-1:0] a_out, a_oe, b_out, b_oe;
   logic         par_out, par_oe, ok_out, ok_oe;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   xfer_parity_transceiver #(.WIDTH(W)) uut (
      .shutdown (shutdown), .dir_a2b (dir_a2b), .odd_sel (odd_sel),
      .a_in (a_in), .a_out (a_out), .a_oe (a_oe),
      .b_in (b_in), .b_out (b_out), .b_oe (b_oe),
      .par_in (par_in), .par_out (par_out), .par_oe (par_oe),
      .ok_out (ok_out), .ok_oe (ok_oe)
   );

   function automatic logic ones_odd(input logic [W-1:0] v);
      int n = 0;
      for (int i = 0; i < W; i++) n += int'(v[i]);
      return logic'(n % 2);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic sd, input logic dir, input logic sel,
                        input logic p, input logic [W-1:0] av, input logic [W-1:0] bv);
      logic on;
      logic xa, xb;
      @(posedge clk);
      shutdown = sd; dir_a2b = dir; odd_sel = sel; par_in = p; a_in = av; b_in = bv;
      @(negedge clk);
      on = ~sd;
      xa = ones_odd(av) ^ sel;
      xb = ~(ones_odd(bv) ^ sel ^ p);
      if (sd) begin
         check("R3 enables", {a_oe, b_oe, par_oe, ok_oe}, '0);
         check("R7 quiet outputs", {a_out, b_out, par_out, ok_out}, '0);
      end else if (dir) begin
         check("R1 a->b", {b_oe, a_oe, b_out}, {{W{1'b1}}, {W{1'b0}}, av});
         check("R4 parity gen", {par_oe, par_out}, {1'b1, xa});
         check("R5 status off", ok_oe, 1'b0);
         check("R7 quiet outputs", {a_out, ok_out}, '0);
      end else begin
         check("R2 b->a", {a_oe, b_oe, a_out}, {{W{1'b1}}, {W{1'b0}}, bv});
         check("R6 parity check", {ok_oe, par_oe, ok_out}, {1'b1, 1'b0, xb});
         check("R7 quiet outputs", {b_out, par_out}, '0);
      end
      if (on === 1'bx) errors++;
   endtask

   initial begin
      #(5.0 * 190000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] ra, rb;
      logic [31:0]  r;
      shutdown = 1'b1; dir_a2b = 1'b0; odd_sel = 1'b0; par_in = 1'b0;
      a_in = '0; b_in = '0;
      @(negedge clk);
      check("R3 initial release", {a_oe, b_oe, par_oe, ok_oe}, '0);

      // directed corners: document examples
      apply(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF);   // R4 even count, sel=1 -> 1
      apply(1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h03);   // R6 even, sel=1, p=1 -> ok
      apply(1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h07);   // R6 odd -> mismatch
      // R5: par_in must not matter while transmitting
      apply(1'b0, 1'b1, 1'b0, 1'b0, 8'hA5, 8'h5A);
      apply(1'b0, 1'b1, 1'b0, 1'b1, 8'hA5, 8'h5A);

      // exhaustive sweep
      for (int s = 0; s < 2; s++)
         for (int d = 0; d < 2; d++)
            for (int o = 0; o < 2; o++)
               for (int p = 0; p < 2; p++)
                  for (int v = 0; v < 256; v++)
                     apply(logic'(s), logic'(d), logic'(o), logic'(p), W'(v), W'(255 - v));

      // seeded random
      r = $urandom(32'd20240611);
      for (int k = 0; k < 2000; k++) begin
         r  = $urandom;
         ra = W'($urandom);
         rb = W'($urandom);
         apply(r[0] & r[1] & r[2], r[3], r[4], r[5], ra, rb);
      end

      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule